// File: doc/BRIEF.md
# Two-wire command front end for a multiplexed converter

This block is the serial slave front end of a multi-channel analog-to-digital converter. It watches the two bus lines (clock and data), which are sampled by the fast system clock, and it pulls the data line low through an open-drain output enable. It recognises start, repeated start and stop conditions. It answers a 7-bit address built from a fixed five-bit prefix `10010` and two strap inputs. The strap inputs are captured while reset is held.

A write transfer carries one or more command bytes. Each command byte sets the input configuration (single-ended against the common input, or a differential pair with selectable polarity), the input channel or channels, and the two power-mode bits. Each command byte also fires a one-cycle conversion-start pulse. A read transfer returns the most recent 10-bit conversion result as two bytes. The result sits right-aligned in the first byte and left-aligned in the second, with zero padding on the outside of each.

Top module: `i2c_adc_cmd_slave`

## Requirements
- R1: While reset is held and after it is released, `sda_oe` and `conv_start` are 0, `se_mode` is 0, `chan_pos` is 0, `chan_neg` is 1 and `pd_mode` is 0.
- R2: An address byte whose bits 7..3 are `10010` and whose bits 2..1 equal the captured strap value is acknowledged. The slave pulls SDA low during the ninth clock. Bit 0 is the direction, where 1 means read and 0 means write.
- R3: After an address byte that does not match, the slave keeps SDA released for every later bit of that transfer, including acknowledge slots, and its decoded outputs do not change.
- R4: `strap_a` is captured only while reset is held. A later change on `strap_a` does not change which address is acknowledged.
- R5: In a write transfer, every complete byte after the address is a command and is acknowledged. Bit 7 selects single-ended mode when 1. Bits 6..4 are C2, C1, C0. Bits 3..2 drive `pd_mode[1:0]`. Bits 1..0 are ignored.
- R6: In differential mode (bit 7 = 0), the pair index is {C1,C0}. With C2 = 0, `chan_pos` = 2·pair and `chan_neg` = 2·pair+1. With C2 = 1, the two are swapped.
- R7: In single-ended mode, `chan_pos` = {C1,C0,C2}, so C2..C0 = `100` selects channel 1. `chan_neg` reads 0, and the negative input is the common input.
- R8: Each completed command byte produces exactly one `conv_start` pulse, one cycle wide. The pulse comes in the same cycle in which the slave starts pulling SDA low for that byte's acknowledge.
- R9: A read transfer returns byte 0 = `0000`,D9..D6 and then byte 1 = D5..D0,`00`, most significant bit first. If the master keeps acknowledging, the two bytes alternate.
- R10: The result sent in a read transfer is the `adc_result` value present when the read address is acknowledged. Later changes do not reach the bytes of that transfer.
- R11: When the master does not acknowledge a read byte, the slave releases SDA. It drives nothing until the next start condition.
- R12: A start condition, repeated or not, opens a new address phase from any point, even in the middle of a byte. A stop condition returns the slave to idle. In both cases a partly received command byte is discarded.
- R13: `sda_oe` changes only while the synchronised SCL is low.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | System clock |
| rst_n | input | 1 | Synchronous active-low reset; strap inputs are captured while it is low |
| strap_a | input | 2 | Address select straps (address bits 2..1) |
| scl_in | input | 1 | Bus clock line, asynchronous |
| sda_in | input | 1 | Bus data line as seen on the wire, asynchronous |
| sda_oe | output | 1 | 1 pulls the data line low; 0 releases it |
| adc_result | input | 10 | Latest conversion result |
| se_mode | output | 1 | 1: single-ended against common; 0: differential |
| chan_pos | output | 3 | Channel routed to the positive input |
| chan_neg | output | 3 | Channel routed to the negative input in differential mode |
| pd_mode | output | 2 | Power-mode bits from the last command |
| conv_start | output | 1 | One-cycle pulse per accepted command byte |

## Verification
Two things can land on the same clock edge. The decode of a completed command byte and the start of that byte's acknowledge are one of them. A repeated start that arrives right after the acknowledge, while the decoded outputs have just settled, is the other. The bench keeps a reference model of the decoded outputs and compares it on every clock. It sends back-to-back command bytes and then a repeated start straight into a read. It judges the result from the acknowledge seen on the wire, the count of conversion pulses and the bytes read back. Starts and stops in the middle of a byte are provoked the same way. Each one must leave the model and the outputs in agreement.

// File: rtl/i2c_adc_pkg.sv
// Package: shared types for the two-wire converter command front end.
// Assumes: a single system clock domain; all consumers import this package.
package i2c_adc_pkg;

    // Transfer phase of the slave byte engine.
    typedef enum logic [2:0] {
        ST_IDLE,
        ST_ADDR,
        ST_WRITE,
        ST_READ,
        ST_DEAF
    } link_state_e;

    // Decoded input-multiplexer and power configuration.
    typedef struct packed {
        logic       se;
        logic [2:0] pos;
        logic [2:0] neg;
        logic [1:0] pd;
    } mux_cfg_t;

endpackage

// File: rtl/i2c_line_sync.sv
// Module: synchronises the bus clock and data lines and flags bus events.
// Assumes: lines are idle-high; STAGES >= 2. Events are combinational
// from registered values and hold for one cycle.
module i2c_line_sync #(
    parameter int STAGES = 2
) (
    input  logic clk,
    input  logic rst_n,
    input  logic scl_raw,
    input  logic sda_raw,
    output logic scl_q,
    output logic sda_q,
    output logic scl_rise,
    output logic scl_fall,
    output logic start_seen,
    output logic stop_seen
);
    localparam int TOP = STAGES - 1;

    logic [TOP:0] scl_pipe, sda_pipe;
    logic         scl_prev, sda_prev;

    // Synchroniser chains plus one history stage for edge detection.
    always_ff @(posedge clk) begin
        if (!rst_n) begin
            scl_pipe <= '1;
            sda_pipe <= '1;
            scl_prev <= 1'b1;
            sda_prev <= 1'b1;
        end else begin
            scl_pipe <= {scl_pipe[TOP-1:0], scl_raw};
            sda_pipe <= {sda_pipe[TOP-1:0], sda_raw};
            scl_prev <= scl_pipe[TOP];
            sda_prev <= sda_pipe[TOP];
        end
    end

    assign scl_q      = scl_pipe[TOP];
    assign sda_q      = sda_pipe[TOP];
    assign scl_rise   = scl_q & ~scl_prev;
    assign scl_fall   = ~scl_q & scl_prev;
    // Data moving while clock stays high is a control condition.
    assign start_seen = scl_q & scl_prev & sda_prev & ~sda_q;
    assign stop_seen  = scl_q & scl_prev & ~sda_prev & sda_q;

endmodule

// File: rtl/adc_cmd_decode.sv
// Module: turns the stored command bits into multiplexer and power settings.
// Assumes: cmd holds byte bits 7..2 (mode, C2, C1, C0, PD1, PD0).
module adc_cmd_decode
    import i2c_adc_pkg::*;
(
    input  logic [5:0] cmd,
    output mux_cfg_t   cfg
);
    logic       c2;
    logic [1:0] pair;

    assign c2   = cmd[4];
    assign pair = cmd[3:2];

    // Channel routing: the pair plus polarity, or a shuffled single index.
    always_comb begin
        cfg.se = cmd[5];
        cfg.pd = cmd[1:0];
        if (cmd[5]) begin
            cfg.pos = {pair, c2};
            cfg.neg = 3'd0;
        end else begin
            cfg.pos = {pair, c2};
            cfg.neg = {pair, ~c2};
        end
    end

endmodule

// File: rtl/adc_result_framer.sv
// Module: picks one of the two read bytes from a held conversion result.
// Assumes: LO_W result bits fill the top of the second byte; the rest
// fill the bottom of the first byte (RES_W - LO_W <= 8).
module adc_result_framer #(
    parameter int RES_W = 10,
    parameter int LO_W  = 6
) (
    input  logic [RES_W-1:0] res,
    input  logic             second,
    output logic [7:0]       tx_byte
);
    localparam int HI_W = RES_W - LO_W;

    // Zero padding above the high part, below the low part.
    always_comb begin
        if (second) tx_byte = {res[LO_W-1:0], {(8-LO_W){1'b0}}};
        else        tx_byte = {{(8-HI_W){1'b0}}, res[RES_W-1:LO_W]};
    end

endmodule

// File: rtl/i2c_adc_cmd_slave.sv
// Module: two-wire slave that takes converter commands and returns results.
// Assumes: system clock at least ~10x the bus clock; address prefix and
// strap match; SDA is only changed by this block while SCL is low.
module i2c_adc_cmd_slave
    import i2c_adc_pkg::*;
#(
    parameter logic [4:0] ADDR_PREFIX = 5'b10010,
    parameter int         RES_W       = 10,
    parameter int         SYNC_STAGES = 2
) (
    input  logic             clk,
    input  logic             rst_n,
    input  logic [1:0]       strap_a,
    input  logic             scl_in,
    input  logic             sda_in,
    output logic             sda_oe,
    input  logic [RES_W-1:0] adc_result,
    output logic             se_mode,
    output logic [2:0]       chan_pos,
    output logic [2:0]       chan_neg,
    output logic [1:0]       pd_mode,
    output logic             conv_start
);
    localparam logic [3:0] ACK_SLOT = 4'd8;
    localparam logic [3:0] ACK_DONE = 4'd9;

    logic             scl_s, sda_s, scl_rise, scl_fall, start_seen, stop_seen;
    link_state_e      state;
    logic [3:0]       bit_cnt;
    logic [7:0]       shreg;
    logic [5:0]       cmd_q;
    logic [1:0]       strap_q;
    logic [RES_W-1:0] res_q;
    logic             byte_sel, mack, in_deaf;
    logic [7:0]       tx_byte;
    mux_cfg_t         cfg;

    i2c_line_sync #(.STAGES(SYNC_STAGES)) u_sync (
        .clk(clk), .rst_n(rst_n), .scl_raw(scl_in), .sda_raw(sda_in),
        .scl_q(scl_s), .sda_q(sda_s), .scl_rise(scl_rise), .scl_fall(scl_fall),
        .start_seen(start_seen), .stop_seen(stop_seen)
    );

    adc_cmd_decode u_dec (.cmd(cmd_q), .cfg(cfg));

    adc_result_framer #(.RES_W(RES_W)) u_frame (
        .res(res_q), .second(byte_sel), .tx_byte(tx_byte)
    );

    assign se_mode  = cfg.se;
    assign chan_pos = cfg.pos;
    assign chan_neg = cfg.neg;
    assign pd_mode  = cfg.pd;
    assign in_deaf  = (state == ST_DEAF);

    // Byte engine: bit counting on SCL edges, address match, ack and data drive.
    always_ff @(posedge clk) begin
        if (!rst_n) begin
            strap_q    <= strap_a;
            state      <= ST_IDLE;
            bit_cnt    <= '0;
            shreg      <= '0;
            cmd_q      <= '0;
            res_q      <= '0;
            byte_sel   <= 1'b0;
            mack       <= 1'b0;
            sda_oe     <= 1'b0;
            conv_start <= 1'b0;
        end else begin
            conv_start <= 1'b0;
            if (start_seen) begin
                state   <= ST_ADDR;
                bit_cnt <= '0;
                sda_oe  <= 1'b0;
            end else if (stop_seen) begin
                state   <= ST_IDLE;
                bit_cnt <= '0;
                sda_oe  <= 1'b0;
            end else if (state != ST_IDLE) begin
                if (scl_rise) begin
                    if (bit_cnt < ACK_SLOT) shreg <= {shreg[6:0], sda_s};
                    else                    mack  <= ~sda_s;
                    if (bit_cnt != ACK_DONE) bit_cnt <= bit_cnt + 4'd1;
                end
                if (scl_fall) begin
                    if (bit_cnt == ACK_SLOT) begin
                        case (state)
                            ST_ADDR: begin
                                if (shreg[7:1] == {ADDR_PREFIX, strap_q}) begin
                                    sda_oe <= 1'b1;
                                    if (shreg[0]) begin
                                        state    <= ST_READ;
                                        res_q    <= adc_result;
                                        byte_sel <= 1'b0;
                                    end else begin
                                        state <= ST_WRITE;
                                    end
                                end else begin
                                    state <= ST_DEAF;
                                end
                            end
                            ST_WRITE: begin
                                cmd_q      <= shreg[7:2];
                                conv_start <= 1'b1;
                                sda_oe     <= 1'b1;
                            end
                            ST_READ: begin
                                sda_oe   <= 1'b0;
                                byte_sel <= ~byte_sel;
                            end
                            default: ;
                        endcase
                    end else if (bit_cnt == ACK_DONE) begin
                        bit_cnt <= '0;
                        // After the address ack the line was held low by this
                        // block, so mack reads as an acknowledge there too.
                        if (state == ST_READ && mack) begin
                            sda_oe <= ~tx_byte[7];
                        end else begin
                            sda_oe <= 1'b0;
                            if (state == ST_READ) state <= ST_DEAF;
                        end
                    end else if (bit_cnt != 4'd0 && state == ST_READ) begin
                        sda_oe <= ~tx_byte[3'd7 - bit_cnt[2:0]];
                    end
                end
            end
        end
    end

endmodule

// File: rtl/i2c_adc_cmd_chk.sv
// Module: protocol and decode checks bound into the command front end.
// Assumes: connected through the bind below; reset is synchronous active-low.
module i2c_adc_cmd_chk (
    input logic       clk,
    input logic       rst_n,
    input logic       sda_oe,
    input logic       conv_start,
    input logic       se_mode,
    input logic [2:0] chan_pos,
    input logic [2:0] chan_neg,
    input logic       scl_s,
    input logic       stop_seen,
    input logic       in_deaf
);
    p_oe_scl_low_r13: assert property (@(posedge clk) disable iff (!rst_n)
        (sda_oe != $past(sda_oe)) |-> !$past(scl_s));

    p_pulse_single_r8: assert property (@(posedge clk) disable iff (!rst_n)
        conv_start |=> !conv_start);

    p_pulse_with_ack_r8: assert property (@(posedge clk) disable iff (!rst_n)
        conv_start |-> sda_oe);

    p_deaf_quiet_r3: assert property (@(posedge clk) disable iff (!rst_n)
        in_deaf |-> !sda_oe);

    p_diff_pair_r6: assert property (@(posedge clk) disable iff (!rst_n)
        !se_mode |-> (chan_pos[2:1] == chan_neg[2:1] && chan_pos[0] != chan_neg[0]));

    p_se_neg_r7: assert property (@(posedge clk) disable iff (!rst_n)
        se_mode |-> (chan_neg == 3'd0));

    p_stop_release_r12: assert property (@(posedge clk) disable iff (!rst_n)
        stop_seen |=> !sda_oe);

endmodule

bind i2c_adc_cmd_slave i2c_adc_cmd_chk u_chk (
    .clk(clk), .rst_n(rst_n), .sda_oe(sda_oe), .conv_start(conv_start),
    .se_mode(se_mode), .chan_pos(chan_pos), .chan_neg(chan_neg),
    .scl_s(scl_s), .stop_seen(stop_seen), .in_deaf(in_deaf)
);

// File: tb/tb_i2c_adc_cmd_slave.sv
// Bench: drives the bus as a master, keeps a behavioural model of the
// decoded outputs and compares it on every clock.
module tb_i2c_adc_cmd_slave;
    logic       clk = 1'b0;
    logic       rst_n = 1'b0;
    logic [1:0] strap = 2'b10;
    logic       m_scl = 1'b1, m_sda = 1'b1;
    logic [9:0] res = 10'd0;
    logic       sda_oe, conv_start, se_mode;
    logic [2:0] chan_pos, chan_neg;
    logic [1:0] pd_mode;
    logic       sda_line;

    always #4 clk = ~clk; // 125 MHz

    assign sda_line = m_sda & ~sda_oe;

    i2c_adc_cmd_slave dut (
        .clk(clk), .rst_n(rst_n), .strap_a(strap), .scl_in(m_scl),
        .sda_in(sda_line), .sda_oe(sda_oe), .adc_result(res),
        .se_mode(se_mode), .chan_pos(chan_pos), .chan_neg(chan_neg),
        .pd_mode(pd_mode), .conv_start(conv_start)
    );

    int n_chk = 0, n_err = 0, pulses = 0;
    bit hold = 1'b1;
    logic       e_se = 1'b0;
    logic [2:0] e_pos = 3'd0, e_neg = 3'd1;
    logic [1:0] e_pd = 2'd0;
    logic       oe_prev = 1'b0;

    task automatic chk(input bit ok, input string tag, input int act, input int exp);
        n_chk++;
        if (!ok) begin
            n_err++;
            $display("FAIL %s actual=%0h expected=%0h", tag, act, exp);
        end
    endtask

    // Model of the command decode, written from the requirements.
    task automatic model_cmd(input logic [7:0] c);
        int pair;
        pair  = {c[5], c[4]};
        e_se  = c[7];
        e_pd  = c[3:2];
        if (c[7]) begin
            e_pos = {c[5], c[4], c[6]};
            e_neg = 3'd0;
        end else begin
            e_pos = 3'(pair * 2 + (c[6] ? 1 : 0));
            e_neg = 3'(pair * 2 + (c[6] ? 0 : 1));
        end
    endtask

    // Every-clock comparison against the model, plus R13 on the wire.
    always @(negedge clk) begin
        if (rst_n) begin
            if (!hold)
                chk({se_mode, chan_pos, chan_neg, pd_mode} == {e_se, e_pos, e_neg, e_pd},
                    "R3/R5/R6/R7/R12 decode vs model",
                    {se_mode, chan_pos, chan_neg, pd_mode}, {e_se, e_pos, e_neg, e_pd});
            chk(!(sda_oe !== oe_prev && m_scl), "R13 sda_oe moved with SCL high",
                sda_oe, oe_prev);
            if (conv_start) pulses++;
        end
        oe_prev <= sda_oe;
    end

    task automatic tick(input int n);
        repeat (n) @(negedge clk);
    endtask

    task automatic do_start;
        m_sda = 1'b1; tick(4); m_scl = 1'b1; tick(8);
        m_sda = 1'b0; tick(8); m_scl = 1'b0; tick(4);
    endtask

    task automatic do_stop;
        m_sda = 1'b0; tick(4); m_scl = 1'b1; tick(8); m_sda = 1'b1; tick(8);
    endtask

    task automatic put_bit(input logic b, output logic seen);
        m_sda = b; tick(4); m_scl = 1'b1; tick(4);
        seen = sda_line; tick(4); m_scl = 1'b0; tick(4);
    endtask

    task automatic send_byte(input logic [7:0] b, output bit acked);
        logic s;
        for (int i = 7; i >= 0; i--) put_bit(b[i], s);
        put_bit(1'b1, s);
        acked = !s;
    endtask

    task automatic recv_byte(input bit give_ack, output logic [7:0] d);
        logic s;
        for (int i = 7; i >= 0; i--) begin
            put_bit(1'b1, s);
            d[i] = s;
        end
        put_bit(!give_ack, s);
    endtask

    task automatic write_cmd(input logic [7:0] c);
        bit a;
        int p0;
        p0   = pulses;
        hold = 1'b1;
        send_byte(c, a);
        chk(a, "R5 command ack", a, 1);
        chk(pulses == p0 + 1, "R8 one conv_start per command", pulses - p0, 1);
        model_cmd(c);
        hold = 1'b0;
    endtask

    function automatic logic [7:0] frame(input logic [9:0] r, input bit second);
        return second ? {r[5:0], 2'b00} : {4'b0000, r[9:6]};
    endfunction

    initial begin
        repeat (200000) @(posedge clk);
        n_err++;
        n_chk++;
        $display("FAIL watchdog expired actual=0 expected=1");
        $display("Result: errors=%0d of %0d checks", n_err, n_chk);
        $finish;
    end

    initial begin
        bit a;
        logic s;
        logic [7:0] d0, d1;
        logic [9:0] snap;

        tick(6);
        chk(sda_oe == 1'b0 && conv_start == 1'b0, "R1 reset outputs", {sda_oe, conv_start}, 0);
        rst_n = 1'b1;
        tick(2);
        chk({se_mode, chan_pos, chan_neg, pd_mode} == {1'b0, 3'd0, 3'd1, 2'd0},
            "R1 decode after reset", {se_mode, chan_pos, chan_neg, pd_mode}, {1'b0, 3'd0, 3'd1, 2'd0});
        hold = 1'b0;
        strap = 2'b01; // R4: straps move after reset

        // R2 matching write address, then a run of commands (R5-R8).
        do_start;
        send_byte({5'b10010, 2'b10, 1'b0}, a);
        chk(a, "R2 address ack with captured strap", a, 1);
        write_cmd(8'h0C);
        write_cmd(8'h50);
        chk(chan_pos == 3'd3 && chan_neg == 3'd2, "R6 swapped pair", {chan_pos, chan_neg}, {3'd3, 3'd2});
        write_cmd(8'h34);
        chk(pd_mode == 2'b01, "R5 power bits", pd_mode, 1);
        write_cmd(8'hC8);
        chk(se_mode && chan_pos == 3'd1, "R7 code 100 selects channel 1", chan_pos, 1);
        write_cmd(8'hF7);
        write_cmd(8'hA3);
        chk(chan_pos == 3'd4 && chan_neg == 3'd0, "R7 single-ended index", {chan_pos, chan_neg}, {3'd4, 3'd0});
        do_stop;

        // R4: the current strap value is not the captured one.
        do_start;
        send_byte({5'b10010, 2'b01, 1'b0}, a);
        chk(!a, "R4 new strap value ignored", a, 0);
        send_byte(8'h08, a);
        chk(!a, "R3 no ack after mismatch", a, 0);
        do_stop;

        // R2: wrong prefix.
        do_start;
        send_byte({5'b10011, 2'b10, 1'b0}, a);
        chk(!a, "R2 prefix mismatch not acked", a, 0);
        do_stop;

        // Command, repeated start, read (R9, R10, R11, R12).
        res = 10'h2C5;
        do_start;
        send_byte({5'b10010, 2'b10, 1'b0}, a);
        write_cmd(8'h8C);
        do_start;
        send_byte({5'b10010, 2'b10, 1'b1}, a);
        chk(a, "R12 read address after repeated start", a, 1);
        snap = res;
        res  = 10'h13A;
        recv_byte(1'b1, d0);
        recv_byte(1'b0, d1);
        chk(d0 == frame(snap, 1'b0), "R9/R10 first read byte", d0, frame(snap, 1'b0));
        chk(d1 == frame(snap, 1'b1), "R9/R10 second read byte", d1, frame(snap, 1'b1));
        chk(sda_oe == 1'b0, "R11 released after master NACK", sda_oe, 0);
        for (int i = 0; i < 9; i++) begin
            put_bit(1'b1, s);
            chk(s == 1'b1, "R11 silent after NACK", s, 1);
        end
        do_stop;

        // Full-scale read with alternating bytes (R9).
        res = 10'h3FF;
        do_start;
        send_byte({5'b10010, 2'b10, 1'b1}, a);
        recv_byte(1'b1, d0);
        recv_byte(1'b1, d1);
        chk(d0 == 8'h0F && d1 == 8'hFC, "R9 full-scale framing", {d0, d1}, 16'h0FFC);
        recv_byte(1'b0, d0);
        chk(d0 == 8'h0F, "R9 bytes alternate", d0, 8'h0F);
        do_stop;

        // R12: start in the middle of a command byte.
        res = 10'h040;
        do_start;
        send_byte({5'b10010, 2'b10, 1'b0}, a);
        for (int i = 0; i < 4; i++) put_bit(1'b1, s);
        do_start;
        send_byte({5'b10010, 2'b10, 1'b1}, a);
        chk(a, "R12 start mid-byte opens address phase", a, 1);
        recv_byte(1'b0, d0);
        chk(d0 == 8'h01, "R12 read after mid-byte start", d0, 8'h01);
        chk(chan_pos == 3'd0 && se_mode, "R12 partial command discarded", chan_pos, 0);
        do_stop;

        // R12: stop in the middle of a command byte, then a clean command.
        do_start;
        send_byte({5'b10010, 2'b10, 1'b0}, a);
        for (int i = 0; i < 5; i++) put_bit(1'b0, s);
        do_stop;
        chk(sda_oe == 1'b0, "R12 idle after stop", sda_oe, 0);
        do_start;
        send_byte({5'b10010, 2'b10, 1'b0}, a);
        chk(a, "R2 address after aborted transfer", a, 1);
        write_cmd(8'h7C);
        chk(chan_pos == 3'd7 && chan_neg == 3'd6, "R6 pair 3 swapped", {chan_pos, chan_neg}, {3'd7, 3'd6});
        do_stop;

        tick(10);
        $display("Result: errors=%0d of %0d checks", n_err, n_chk);
        $finish;
    end

endmodule